// File: doc/BRIEF.md
# Rolling-Shutter Readout Sequencer

This block sequences a directly addressed pixel array. The array has one shared binary address bus and separate latch strobes for the row decoder and the column decoder. A row is read by latching its row address and then pulsing a row-load strobe, which ties that row to the column amplifiers. Each pixel is then reached by latching column addresses one after another. A row is cleared by latching its row address and pulsing a row-reset strobe.

The sequencer runs whole frames with a rolling shutter. At the start of a frame it resets the first N rows with no readout, which primes the shutter. It then reads rows 0 to R-1 in ascending order. After each row's last pixel it resets row r+N, so every row integrates for exactly N row slots.

After each column latch, a programmable settle delay elapses and then a one-cycle pixel-valid strobe is emitted. This strobe carries the row and column indices and gives the sample timing for an external converter. Frames repeat back to back until a stop request is made. A one-cycle frame-done pulse marks the end of every frame.

Top module: `rs_readout_seq`

## Requirements
- R1: After reset, and whenever idle, `busy_o` is 0, all strobes are 0, `addr_o` is 0, and the pixel row and column outputs are 0.
- R2: At most one of `y_lat_o`, `x_lat_o`, `row_rd_o` and `row_rst_o` is high in any cycle. Each latch strobe lasts one cycle, and `addr_o` holds the target address in the cycle before the strobe, during it and in the cycle after it.
- R3: A frame starts in the cycle after `start_i` is sampled. It first resets rows 0 to N-1 in ascending order. Each reset takes 4 cycles: address setup, `y_lat_o`, hold, then `row_rst_o` with the address still driven.
- R4: Reading row r takes 4 cycles of row setup: address r, `y_lat_o`, hold, then `row_rd_o` with address r. The columns of the row are then scanned in ascending order from 0 to C-1.
- R5: Each column takes 4+S cycles: address setup, `x_lat_o`, hold, S wait cycles, then `pix_vld_o`. `pix_vld_o` carries the current row on `pix_row_o` and the current column on `pix_col_o`, and comes S+2 cycles after `x_lat_o`.
- R6: After the last pixel of row r, if r+N < R, row r+N is reset (same 4-cycle form as R3) before the next row's address is latched. Otherwise the next read follows directly.
- R7: Count the row slots in a frame, where a slot is one priming reset or one row read. Every row that is read was reset in the same frame, exactly N slots earlier.
- R8: N (`int_rows_i`) and S (`settle_i`) are sampled only when a frame begins. Changes made during a frame take effect at the next frame. An N of 0 is treated as 1.
- R9: `frame_done_o` is high for exactly one cycle, the cycle after the last operation of the frame. The frame length is R*(8+C*(4+S))+1 cycles. If no stop is pending, the next frame's first cycle follows at once.
- R10: A stop request (`stop_i`) made while busy lets the current frame finish. The block then goes idle after `frame_done_o`. A stop request made while idle has no effect.
- R11: `start_i` has no effect while a frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin frames when idle |
| stop_i | input | 1 | Request idle at the end of the current frame |
| int_rows_i | input | ROW_W | Integration length N in row slots |
| settle_i | input | SETTLE_W | Settle wait S in cycles after each column hold |
| addr_o | output | max(ROW_W,COL_W) | Shared decoder address bus |
| y_lat_o | output | 1 | Latch the bus into the row decoder |
| x_lat_o | output | 1 | Latch the bus into the column decoder |
| row_rd_o | output | 1 | Connect the latched row to the column amplifiers |
| row_rst_o | output | 1 | Reset the latched row |
| pix_vld_o | output | 1 | Pixel sample strobe |
| pix_row_o | output | ROW_W | Row index of the strobed pixel |
| pix_col_o | output | COL_W | Column index of the strobed pixel |
| busy_o | output | 1 | Frame in progress |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
All outputs are decoded from the state register, so each result appears in the first cycle after the clock edge that enters its state. The start sample is followed one cycle later by the row setup, a latch strobe is followed S+2 cycles later by pixel-valid, and the end of the last operation is followed one cycle later by frame-done. The bench walks its own arithmetic model of the frame in lockstep, one negative edge per cycle. It compares every output in every cycle, so any shift of even one cycle is caught. A separate monitor counts row slots from the strobes alone and checks the N-slot spacing between the reset and the read of each row.

// File: rtl/rs_seq_pkg.sv
package rs_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_Y_SU, ST_Y_ST, ST_Y_HD, ST_RST, ST_RD,
    ST_X_SU, ST_X_ST, ST_X_HD, ST_WAIT, ST_VLD, ST_DONE
  } seq_st_e;
endpackage

// File: rtl/rs_row_plan.sv
// Chooses the operation that follows a finished reset or a finished row read.
module rs_row_plan #(
  parameter int ROW_W = 10
) (
  input  logic             ended_read_i,
  input  logic             prime_i,
  input  logic [ROW_W-1:0] op_row_i,
  input  logic [ROW_W-1:0] rd_row_i,
  input  logic [ROW_W-1:0] n_i,
  output logic             nxt_done_o,
  output logic             nxt_rst_o,
  output logic             nxt_prime_o,
  output logic [ROW_W-1:0] nxt_row_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = '1;

  logic [ROW_W:0] prime_nxt;
  logic [ROW_W:0] trail_row;
  logic           last_read;

  assign prime_nxt = {1'b0, op_row_i} + 1'b1;
  assign trail_row = {1'b0, rd_row_i} + {1'b0, n_i};
  assign last_read = (rd_row_i == LAST_ROW);

  always_comb begin
    nxt_done_o  = 1'b0;
    nxt_rst_o   = 1'b0;
    nxt_prime_o = 1'b0;
    nxt_row_o   = rd_row_i + 1'b1;
    if (ended_read_i) begin
      if (!trail_row[ROW_W]) begin
        nxt_rst_o = 1'b1;
        nxt_row_o = trail_row[ROW_W-1:0];
      end else if (last_read) begin
        nxt_done_o = 1'b1;
      end
    end else if (prime_i) begin
      if (prime_nxt < {1'b0, n_i}) begin
        nxt_rst_o   = 1'b1;
        nxt_prime_o = 1'b1;
        nxt_row_o   = prime_nxt[ROW_W-1:0];
      end else begin
        nxt_row_o = '0;
      end
    end else if (last_read) begin
      nxt_done_o = 1'b1;
    end
  end
endmodule

// File: rtl/rs_settle_cnt.sv
module rs_settle_cnt #(
  parameter int SETTLE_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [SETTLE_W-1:0] limit_i,
  output logic                expired_o
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
    else             cnt_q <= '0;
  end

  assign expired_o = run_i && (cnt_q == limit_i - 1'b1);

  p_wait_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/rs_readout_seq.sv
module rs_readout_seq
  import rs_seq_pkg::*;
#(
  parameter int ROW_W    = 10,
  parameter int COL_W    = 10,
  parameter int SETTLE_W = 4,
  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [ROW_W-1:0]    int_rows_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                y_lat_o,
  output logic                x_lat_o,
  output logic                row_rd_o,
  output logic                row_rst_o,
  output logic                pix_vld_o,
  output logic [ROW_W-1:0]    pix_row_o,
  output logic [COL_W-1:0]    pix_col_o,
  output logic                busy_o,
  output logic                frame_done_o
);
  localparam logic [COL_W-1:0] LAST_COL = '1;

  seq_st_e             st_q, st_d;
  logic [ROW_W-1:0]    op_row_q, op_row_d, rd_row_q, rd_row_d, n_q, n_d, eff_n;
  logic [COL_W-1:0]    col_q, col_d;
  logic [SETTLE_W-1:0] s_q, s_d;
  logic                prime_q, prime_d, op_rst_q, op_rst_d, stop_q;
  logic                frame_go, wait_done;
  logic                pl_done, pl_rst, pl_prime;
  logic [ROW_W-1:0]    pl_row;

  assign eff_n = (int_rows_i == '0) ? ROW_W'(1) : int_rows_i;

  rs_row_plan #(.ROW_W(ROW_W)) u_plan (
    .ended_read_i (st_q == ST_VLD),
    .prime_i      (prime_q),
    .op_row_i     (op_row_q),
    .rd_row_i     (rd_row_q),
    .n_i          (n_q),
    .nxt_done_o   (pl_done),
    .nxt_rst_o    (pl_rst),
    .nxt_prime_o  (pl_prime),
    .nxt_row_o    (pl_row)
  );

  rs_settle_cnt #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (st_q == ST_WAIT),
    .limit_i   (s_q),
    .expired_o (wait_done)
  );

  always_comb begin
    st_d     = st_q;
    op_row_d = op_row_q;
    rd_row_d = rd_row_q;
    col_d    = col_q;
    prime_d  = prime_q;
    op_rst_d = op_rst_q;
    n_d      = n_q;
    s_d      = s_q;
    frame_go = 1'b0;
    unique case (st_q)
      ST_IDLE: frame_go = start_i;
      ST_Y_SU: st_d = ST_Y_ST;
      ST_Y_ST: st_d = ST_Y_HD;
      ST_Y_HD: st_d = op_rst_q ? ST_RST : ST_RD;
      ST_RD: begin
        col_d = '0;
        st_d  = ST_X_SU;
      end
      ST_X_SU: st_d = ST_X_ST;
      ST_X_ST: st_d = ST_X_HD;
      ST_X_HD: st_d = (s_q == '0) ? ST_VLD : ST_WAIT;
      ST_WAIT: if (wait_done) st_d = ST_VLD;
      ST_RST, ST_VLD: begin
        if (st_q == ST_VLD && col_q != LAST_COL) begin
          col_d = col_q + 1'b1;
          st_d  = ST_X_SU;
        end else if (pl_done) begin
          st_d = ST_DONE;
        end else begin
          st_d     = ST_Y_SU;
          op_row_d = pl_row;
          op_rst_d = pl_rst;
          prime_d  = pl_prime;
          if (!pl_rst) rd_row_d = pl_row;
        end
      end
      ST_DONE: begin
        if (stop_q || stop_i) st_d = ST_IDLE;
        else                  frame_go = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (frame_go) begin
      st_d     = ST_Y_SU;
      n_d      = eff_n;
      s_d      = settle_i;
      prime_d  = 1'b1;
      op_rst_d = 1'b1;
      op_row_d = '0;
      rd_row_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_row_q <= '0;
      rd_row_q <= '0;
      col_q    <= '0;
      prime_q  <= 1'b0;
      op_rst_q <= 1'b0;
      n_q      <= ROW_W'(1);
      s_q      <= '0;
      stop_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      op_row_q <= op_row_d;
      rd_row_q <= rd_row_d;
      col_q    <= col_d;
      prime_q  <= prime_d;
      op_rst_q <= op_rst_d;
      n_q      <= n_d;
      s_q      <= s_d;
      if (st_q == ST_IDLE) stop_q <= 1'b0;
      else if (stop_i)     stop_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_Y_SU, ST_Y_ST, ST_Y_HD, ST_RST, ST_RD: addr_o = ADDR_W'(op_row_q);
      ST_X_SU, ST_X_ST, ST_X_HD, ST_WAIT, ST_VLD: addr_o = ADDR_W'(col_q);
      default: addr_o = '0;
    endcase
  end

  assign y_lat_o      = (st_q == ST_Y_ST);
  assign x_lat_o      = (st_q == ST_X_ST);
  assign row_rd_o     = (st_q == ST_RD);
  assign row_rst_o    = (st_q == ST_RST);
  assign pix_vld_o    = (st_q == ST_VLD);
  assign pix_row_o    = pix_vld_o ? rd_row_q : '0;
  assign pix_col_o    = pix_vld_o ? col_q : '0;
  assign busy_o       = (st_q != ST_IDLE);
  assign frame_done_o = (st_q == ST_DONE);

  p_single_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({y_lat_o, x_lat_o, row_rd_o, row_rst_o}));
  p_y_addr_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_lat_o |-> $stable(addr_o));
  p_y_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_lat_o |=> $stable(addr_o));
  p_x_addr_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_lat_o |-> $stable(addr_o));
  p_x_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_lat_o |=> $stable(addr_o));
  p_load_after_ylat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_rd_o |-> ($past(y_lat_o, 2) && $stable(addr_o)));
  p_reset_after_ylat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_rst_o |-> ($past(y_lat_o, 2) && $stable(addr_o)));
  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (addr_o == '0 && !y_lat_o && !x_lat_o && !pix_vld_o));
endmodule

// File: tb/tb_rs_readout_seq.sv
`timescale 1ns/1ps
module tb_rs_readout_seq;
  localparam int ROW_W = 3, COL_W = 2, SETTLE_W = 3;
  localparam int ADDR_W = 3, ROWS = 8, COLS = 4;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, stop_i = 1'b0;
  logic [ROW_W-1:0] int_rows_i = '0;
  logic [SETTLE_W-1:0] settle_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic y_lat_o, x_lat_o, row_rd_o, row_rst_o, pix_vld_o, busy_o, frame_done_o;
  logic [ROW_W-1:0] pix_row_o;
  logic [COL_W-1:0] pix_col_o;

  int total = 0, bad = 0, fc = 0, cur_n = 1;
  int drop_at = -1, stop_at = -1, chg_at = -1, chg_n = 0, chg_s = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rs_readout_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .SETTLE_W(SETTLE_W)) dut (
    .clk_i(clk), .rst_ni, .start_i, .stop_i, .int_rows_i, .settle_i,
    .addr_o, .y_lat_o, .x_lat_o, .row_rd_o, .row_rst_o, .pix_vld_o,
    .pix_row_o, .pix_col_o, .busy_o, .frame_done_o);

  // one cycle of the lockstep model: sample at negedge, compare, then drive
  task automatic exp(string tag, int a, bit y, bit x, bit rd, bit rs, bit v,
                     int pr, int pc, bit dn, bit bz);
    logic [17:0] got, want;
    @(negedge clk);
    got  = {addr_o, y_lat_o, x_lat_o, row_rd_o, row_rst_o, pix_vld_o,
            pix_row_o, pix_col_o, frame_done_o, busy_o};
    want = {ADDR_W'(a), y, x, rd, rs, v, ROW_W'(pr), COL_W'(pc), dn, bz};
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s cycle %0d got=%h exp=%h", tag, fc, got, want);
    end
    if (fc == drop_at) start_i = 1'b0;
    stop_i = (fc == stop_at);
    if (fc == chg_at) begin
      int_rows_i = ROW_W'(chg_n);
      settle_i   = SETTLE_W'(chg_s);
    end
    fc++;
  endtask

  task automatic rst_op(int k, string tag);
    exp(tag,  k, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    exp("R2", k, 1, 0, 0, 0, 0, 0, 0, 0, 1);
    exp(tag,  k, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    exp(tag,  k, 0, 0, 0, 1, 0, 0, 0, 0, 1);
  endtask

  task automatic run_frame(int nraw, int s, string ptag);
    int n;
    n = (nraw == 0) ? 1 : nraw;
    cur_n = n;
    fc = 0;
    for (int p = 0; p < n; p++) rst_op(p, ptag);
    for (int r = 0; r < ROWS; r++) begin
      exp("R4", r, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      exp("R2", r, 1, 0, 0, 0, 0, 0, 0, 0, 1);
      exp("R4", r, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      exp("R4", r, 0, 0, 1, 0, 0, 0, 0, 0, 1);
      for (int c = 0; c < COLS; c++) begin
        exp("R5", c, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        exp("R2", c, 0, 1, 0, 0, 0, 0, 0, 0, 1);
        exp("R2", c, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        for (int w = 0; w < s; w++) exp("R5", c, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        exp("R5", c, 0, 0, 0, 0, 1, r, c, 0, 1);
      end
      if (r + n < ROWS) rst_op(r + n, "R6");
    end
    exp("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
  endtask

  task automatic idle_chk(int k, string tag);
    for (int i = 0; i < k; i++) exp(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic kick(int n, int s, int drop, int stp);
    @(negedge clk);
    int_rows_i = ROW_W'(n);
    settle_i   = SETTLE_W'(s);
    start_i    = 1'b1;
    drop_at = drop; stop_at = stp; chg_at = -1;
  endtask

  // R7 monitor: slot spacing taken from strobes only
  int slot = 0; bit any_rd = 0;
  int rst_slot [ROWS];
  bit seen [ROWS];
  always @(negedge clk) begin
    if (rst_ni) begin
      if (row_rst_o) begin
        if (!any_rd) slot++;
        rst_slot[addr_o] = slot;
        seen[addr_o] = 1;
      end
      if (row_rd_o) begin
        slot++;
        any_rd = 1;
        total++;
        if (!seen[addr_o] || slot - rst_slot[addr_o] != cur_n) begin
          bad++;
          $display("FAIL R7 row %0d spacing got=%0d exp=%0d seen=%0d",
                   addr_o, slot - rst_slot[addr_o], cur_n, seen[addr_o]);
        end
      end
      if (frame_done_o) begin
        slot = 0; any_rd = 0;
        for (int i = 0; i < ROWS; i++) seen[i] = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle_chk(3, "R1");
    // R10: stop while idle has no effect
    @(negedge clk); stop_i = 1'b1;
    idle_chk(2, "R10");
    // sweep of N and S, single frames stopped early
    for (int n = 0; n < ROWS; n++) begin
      for (int s = 0; s < 4; s += (s == 1) ? 2 : 1) begin
        kick(n, s, 0, 5);
        run_frame(n, s, (n == 0) ? "R8" : "R3");
        idle_chk(2, "R10");
      end
    end
    // R8 + R9: config change mid-frame, back-to-back frames
    kick(3, 1, 0, -1);
    chg_at = 10; chg_n = 5; chg_s = 0;
    run_frame(3, 1, "R3");
    chg_at = -1; stop_at = 7;
    run_frame(5, 0, "R8");
    idle_chk(3, "R10");
    // R11: start held high during the frame
    kick(2, 2, 100, 3);
    run_frame(2, 2, "R11");
    idle_chk(3, "R11");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule